// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block holds the programming state of a 24-input interrupt router. Software reaches it through two 32-bit words on a small request interface. One word is a select register. The other is a data window that opens onto whatever the select register currently points at: an identification word, a read-only version word, an arbitration word (which mirrors the identification word), or one half of a 64-bit redirection entry. Every entry is also driven out in parallel as a flat vector, so a delivery engine can use all of them at once.

Each entry has two status flags that hardware owns: a level-acknowledge flag at bit 14 and a pending-delivery flag at bit 12. Software writes cannot change them. The delivery engine changes them through a side port. After every accepted entry write, the block raises a one-cycle strobe that carries the entry number. It also sets a sticky per-entry "used" flag, so the delivery engine knows to reload that entry.

Requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Writes produce no response. Each accepted read produces exactly one response on the next cycle. The response stays stable until `rsp_ready` is seen high. While a response is held, `req_ready` is low, so at most one read is ever outstanding.

Top module: `irq_route_regs`

## Requirements
- R1: After reset, every entry reads 0x0000_0000_0001_0000 (mask bit 16 set). The used flags, `upd_strobe` and `rsp_valid` are all low, and `req_ready` is high.
- R2: A 4-byte write at byte offset 0x00 loads the 32-bit select register, and a read there returns it. A write to any offset other than 0x00 or 0x10 changes nothing. A read at such an offset returns `rsp_err`=1 with data 0.
- R3: A request whose `req_size` is not 4 is dropped when it is a write. When it is a read, it gets an error response (`rsp_err`=1, data 0).
- R4: With select index 0x01, the window reads 0x00170011 (entry count minus one in bits 23:16, version code 0x11 in bits 7:0). Window writes to this index change nothing.
- R5: With select index 0x00, a window write stores bits 27:24 of the data as a 4-bit ID. Index 0x00 and index 0x02 both read the ID back in bits 27:24, with all other bits zero.
- R6: Select indices 0x10 to 0x3F map to entries by entry = (index − 0x10) / 2. An even index reaches bits 31:0 and an odd index reaches bits 63:32. The select index is bits 7:0 of the select register.
- R7: A window write to a low half replaces the low 32 bits under mask 0xFFFF_AFFF. Bits 12 and 14 keep their previous values.
- R8: A window write to a high half replaces bits 63:32 of that entry completely.
- R9: Any other select index reads as 0 with `rsp_err`=0. A window write to it changes no entry and raises no strobe.
- R10: An accepted entry write drives `upd_strobe` high for exactly the next cycle, with `upd_entry` set to the entry number. The same write sets that entry's used flag, which stays set until reset.
- R11: A cycle with `hw_upd_valid` high applies its updates to entry `hw_upd_entry` on the next clock edge. When `hw_irr_we` is high, bit 14 takes `hw_irr_val`. When `hw_ds_we` is high, bit 12 takes `hw_ds_val`.
- R12: An accepted read gives `rsp_valid` on the next cycle. `rsp_data` and `rsp_err` hold until `rsp_ready` is high, and `req_ready` stays low while `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset (0x00 select, 0x10 window) |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 32 | Read data |
| rsp_err | output | 1 | Read hit an invalid offset or size |
| hw_upd_valid | input | 1 | Status update from delivery engine |
| hw_upd_entry | input | 5 | Entry the status update targets |
| hw_irr_we | input | 1 | Update bit 14 |
| hw_irr_val | input | 1 | New bit 14 value |
| hw_ds_we | input | 1 | Update bit 12 |
| hw_ds_val | input | 1 | New bit 12 value |
| entries_o | output | 1536 | All entries, entry n at bits n*64+63 : n*64 |
| used_o | output | 24 | Sticky per-entry written flags |
| upd_strobe | output | 1 | One-cycle pulse after an entry write |
| upd_entry | output | 5 | Entry number carried with the strobe |

## Verification
The window is driven with all-ones and all-zeros data on low halves, both before and after the delivery engine sets the status flags. This separates a correct masked merge from a plain overwrite and from a merge that loses hardware-set bits. The bench uses the first entry, a middle entry and the last entry, with both even and odd selects, so an off-by-one or a swapped half in the index arithmetic shows up. It also sends wrong sizes, stray offsets, undefined indices and the version index with non-zero data, and compares the entry vector with a snapshot to catch any stray effect. A response held under back-pressure shows whether the read data and the ready signal stay frozen.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned ENTRY_W = 64;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;
  localparam logic [31:0] LO_WMASK = 32'hFFFF_AFFF;
  localparam int unsigned BIT_PEND = 12;
  localparam int unsigned BIT_ACK = 14;
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] IDX_ID = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_ARB = 8'h02;
  localparam logic [7:0] IDX_WIN_BASE = 8'h10;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_ENT
  } tgt_e;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_ENT = 24,
  localparam int unsigned IDX_W = $clog2(NUM_ENT)
) (
  input  logic [7:0]       sel_idx,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] ent_num,
  output logic             ent_hi
);
  localparam int unsigned WIN_LAST = 16 + 2 * NUM_ENT - 1;

  logic [7:0] win_off;

  assign win_off = sel_idx - IDX_WIN_BASE;
  assign ent_hi  = sel_idx[0];

  always_comb begin
    tgt     = TGT_NONE;
    ent_num = '0;
    if (sel_idx == IDX_ID) begin
      tgt = TGT_ID;
    end else if (sel_idx == IDX_VER) begin
      tgt = TGT_VER;
    end else if (sel_idx == IDX_ARB) begin
      tgt = TGT_ARB;
    end else if (sel_idx >= IDX_WIN_BASE && 32'(sel_idx) <= WIN_LAST) begin
      tgt     = TGT_ENT;
      ent_num = win_off[IDX_W:1];
    end
  end
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_we_lo,
  input  logic        sw_we_hi,
  input  logic [31:0] sw_wdata,
  input  logic        hw_ack_we,
  input  logic        hw_ack_val,
  input  logic        hw_pend_we,
  input  logic        hw_pend_val,
  output logic [63:0] q
);
  logic [63:0] nxt;

  always_comb begin
    nxt = q;
    if (sw_we_hi) nxt[63:32] = sw_wdata;
    if (sw_we_lo) nxt[31:0] = (q[31:0] & ~LO_WMASK) | (sw_wdata & LO_WMASK);
    if (hw_ack_we) nxt[BIT_ACK] = hw_ack_val;
    if (hw_pend_we) nxt[BIT_PEND] = hw_pend_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= ENTRY_RST;
    else        q <= nxt;
  end
endmodule

// File: rtl/irq_route_rsp.sv
module irq_route_rsp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] ld_data,
  input  logic        ld_err,
  input  logic        rsp_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        rsp_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= ld_data;
      rsp_err   <= ld_err;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_ENT  = 24,
  parameter logic [7:0]  VER_CODE = 8'h11,
  localparam int unsigned IDX_W = $clog2(NUM_ENT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [7:0]              req_offset,
  input  logic [2:0]              req_size,
  input  logic [31:0]             req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [31:0]             rsp_data,
  output logic                    rsp_err,
  input  logic                    hw_upd_valid,
  input  logic [IDX_W-1:0]        hw_upd_entry,
  input  logic                    hw_irr_we,
  input  logic                    hw_irr_val,
  input  logic                    hw_ds_we,
  input  logic                    hw_ds_val,
  output logic [NUM_ENT*64-1:0]   entries_o,
  output logic [NUM_ENT-1:0]      used_o,
  output logic                    upd_strobe,
  output logic [IDX_W-1:0]        upd_entry
);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENT - 1), 8'h00, VER_CODE};

  logic [31:0]      sel_q;
  logic [3:0]       id_q;
  logic [63:0]      ent_q [NUM_ENT];
  tgt_e             tgt;
  logic [IDX_W-1:0] ent_num;
  logic             ent_hi;
  logic             acc, size_ok, at_sel, at_win;
  logic             wr_sel, wr_win, wr_ent;
  logic [31:0]      rd_word;
  logic             rd_bad;

  assign req_ready = ~rsp_valid;
  assign acc       = req_valid & req_ready;
  assign size_ok   = (req_size == 3'd4);
  assign at_sel    = (req_offset == OFF_SEL);
  assign at_win    = (req_offset == OFF_WIN);
  assign wr_sel    = acc & req_write & size_ok & at_sel;
  assign wr_win    = acc & req_write & size_ok & at_win;
  assign wr_ent    = wr_win & (tgt == TGT_ENT);

  irq_route_decode #(.NUM_ENT(NUM_ENT)) u_dec (
    .sel_idx (sel_q[7:0]),
    .tgt     (tgt),
    .ent_num (ent_num),
    .ent_hi  (ent_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q      <= '0;
      id_q       <= '0;
      used_o     <= '0;
      upd_strobe <= 1'b0;
      upd_entry  <= '0;
    end else begin
      if (wr_sel) sel_q <= req_wdata;
      if (wr_win && tgt == TGT_ID) id_q <= req_wdata[27:24];
      upd_strobe <= wr_ent;
      if (wr_ent) begin
        upd_entry       <= ent_num;
        used_o[ent_num] <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic hit_hw;
    logic hit_sw;
    assign hit_hw = hw_upd_valid & (hw_upd_entry == IDX_W'(i));
    assign hit_sw = wr_ent & (ent_num == IDX_W'(i));

    irq_route_entry u_ent (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw_we_lo    (hit_sw & ~ent_hi),
      .sw_we_hi    (hit_sw & ent_hi),
      .sw_wdata    (req_wdata),
      .hw_ack_we   (hit_hw & hw_irr_we),
      .hw_ack_val  (hw_irr_val),
      .hw_pend_we  (hit_hw & hw_ds_we),
      .hw_pend_val (hw_ds_val),
      .q           (ent_q[i])
    );
    assign entries_o[i*64 +: 64] = ent_q[i];
  end

  always_comb begin
    rd_word = '0;
    rd_bad  = ~size_ok | ~(at_sel | at_win);
    if (!rd_bad) begin
      if (at_sel) begin
        rd_word = sel_q;
      end else begin
        unique case (tgt)
          TGT_ID, TGT_ARB: rd_word = {4'h0, id_q, 24'h0};
          TGT_VER:         rd_word = VER_WORD;
          TGT_ENT:         rd_word = ent_hi ? ent_q[ent_num][63:32] : ent_q[ent_num][31:0];
          default:         rd_word = '0;
        endcase
      end
    end
  end

  irq_route_rsp u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc & ~req_write),
    .ld_data   (rd_word),
    .ld_err    (rd_bad),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err)
  );
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int unsigned NUM_ENT = 24,
  localparam int unsigned IDX_W = $clog2(NUM_ENT)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_ready,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [31:0]           rsp_data,
  input logic                  rsp_err,
  input logic                  hw_upd_valid,
  input logic [NUM_ENT*64-1:0] entries_o,
  input logic [NUM_ENT-1:0]    used_o,
  input logic                  upd_strobe,
  input logic [IDX_W-1:0]      upd_entry
);
  logic [2*NUM_ENT-1:0] ro_bits;
  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ro
    assign ro_bits[2*i]   = entries_o[i*64 + 12];
    assign ro_bits[2*i+1] = entries_o[i*64 + 14];
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (used_o == '0 && !rsp_valid && !upd_strobe));

  assert_ro_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hw_upd_valid) |-> $stable(ro_bits));

  assert_strobe_used_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> used_o[upd_entry]);

  assert_used_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(used_o) & ~used_o) == '0);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind irq_route_regs irq_route_regs_chk #(.NUM_ENT(NUM_ENT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .rsp_err      (rsp_err),
  .hw_upd_valid (hw_upd_valid),
  .entries_o    (entries_o),
  .used_o       (used_o),
  .upd_strobe   (upd_strobe),
  .upd_entry    (upd_entry)
);

// File: tb/irq_route_regs_test.sv
module irq_route_regs_test;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_offset = '0;
  logic [2:0] req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic hw_upd_valid = 1'b0, hw_irr_we = 1'b0, hw_irr_val = 1'b0, hw_ds_we = 1'b0, hw_ds_val = 1'b0;
  logic [4:0] hw_upd_entry = '0;
  logic req_ready, rsp_valid, rsp_err, upd_strobe;
  logic [31:0] rsp_data;
  logic [N*64-1:0] entries_o;
  logic [N-1:0] used_o;
  logic [4:0] upd_entry;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  irq_route_regs uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .hw_upd_valid(hw_upd_valid), .hw_upd_entry(hw_upd_entry),
    .hw_irr_we(hw_irr_we), .hw_irr_val(hw_irr_val), .hw_ds_we(hw_ds_we), .hw_ds_val(hw_ds_val),
    .entries_o(entries_o), .used_o(used_o), .upd_strobe(upd_strobe), .upd_entry(upd_entry)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ent(input int n);
    return entries_o[n*64 +: 64];
  endfunction

  task automatic bus_wr(input logic [7:0] off, input logic [31:0] d, input logic [2:0] sz = 3'd4);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_offset = off; req_wdata = d; req_size = sz;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_size = 3'd4;
  endtask

  task automatic bus_rd(input logic [7:0] off, output logic [31:0] d, output logic e,
                        input logic [2:0] sz = 3'd4);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = off; req_size = sz;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_size = 3'd4;
    d = rsp_valid ? rsp_data : 32'hDEAD_DEAD;
    e = rsp_err;
  endtask

  task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
    logic e;
    bus_wr(8'h00, {24'h0, idx});
    bus_rd(8'h10, d, e);
  endtask

  task automatic hw_upd(input int n, input logic iwe, input logic iv, input logic dwe, input logic dv);
    hw_upd_valid = 1'b1; hw_upd_entry = 5'(n);
    hw_irr_we = iwe; hw_irr_val = iv; hw_ds_we = dwe; hw_ds_val = dv;
    @(posedge clk);
    @(negedge clk);
    hw_upd_valid = 1'b0; hw_irr_we = 1'b0; hw_ds_we = 1'b0;
  endtask

  task automatic t_reset();
    int nbad = 0;
    for (int i = 0; i < N; i++) if (ent(i) !== 64'h0000_0000_0001_0000) nbad++;
    chk("R1 entries reset", 64'(nbad), 0);
    chk("R1 used", 64'(used_o), 0);
    chk("R1 strobe/rsp/ready", {upd_strobe, rsp_valid, req_ready}, 3'b001);
  endtask

  task automatic t_select();
    logic [31:0] d; logic e;
    bus_wr(8'h00, 32'hABCD_0012);
    bus_rd(8'h00, d, e);
    chk("R2 select readback", {e, d}, {1'b0, 32'hABCD_0012});
    bus_wr(8'h08, 32'h0000_0005);
    bus_rd(8'h00, d, e);
    chk("R2 stray offset write ignored", d, 32'hABCD_0012);
    bus_rd(8'h04, d, e);
    chk("R2 stray offset read", {e, d}, {1'b1, 32'h0});
  endtask

  task automatic t_size();
    logic [31:0] d; logic e;
    bus_wr(8'h00, 32'h0000_0011, 3'd2);
    bus_rd(8'h00, d, e);
    chk("R3 narrow write dropped", d, 32'hABCD_0012);
    bus_rd(8'h00, d, e, 3'd1);
    chk("R3 narrow read error", {e, d}, {1'b1, 32'h0});
  endtask

  task automatic t_version();
    logic [31:0] d;
    win_rd(8'h01, d);
    chk("R4 version word", d, 32'h0017_0011);
    bus_wr(8'h10, 32'h0);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    win_rd(8'h01, d);
    chk("R4 version after writes", d, 32'h0017_0011);
  endtask

  task automatic t_id();
    logic [31:0] d;
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h10, 32'hF5A3_1234);
    win_rd(8'h00, d);
    chk("R5 id readback", d, 32'h0500_0000);
    win_rd(8'h02, d);
    chk("R5 arb mirrors id", d, 32'h0500_0000);
  endtask

  task automatic t_entry();
    logic [31:0] d;
    bus_wr(8'h00, 32'h16);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    chk("R10 strobe and entry", {upd_strobe, 3'b000, upd_entry}, {1'b1, 3'b000, 5'd3});
    chk("R10 used flag", 64'(used_o), 64'(24'h000008));
    chk("R7 low write masked", ent(3), 64'h0000_0000_FFFF_AFFF);
    @(negedge clk);
    chk("R10 strobe one cycle", 64'(upd_strobe), 0);
    win_rd(8'h16, d);
    chk("R6 low half read", d, 32'hFFFF_AFFF);
    hw_upd(3, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R11 hw set bits", ent(3), 64'h0000_0000_FFFF_FFFF);
    bus_wr(8'h10, 32'h0);
    chk("R7 low write keeps status", ent(3), 64'h0000_0000_0000_5000);
    hw_upd(3, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R11 hw clear ack only", ent(3), 64'h0000_0000_0000_1000);
    hw_upd(3, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R11 hw clear pend", ent(3), 64'h0);
    bus_wr(8'h00, 32'h17);
    bus_wr(8'h10, 32'hDEAD_BEEF);
    chk("R8 high write", ent(3), 64'hDEAD_BEEF_0000_0000);
    win_rd(8'h17, d);
    chk("R6 high half read", d, 32'hDEAD_BEEF);
    bus_wr(8'h00, 32'h3F);
    bus_wr(8'h10, 32'h1234_5678);
    chk("R6 last entry high", ent(23), 64'h1234_5678_0001_0000);
    chk("R10 last strobe", 64'(upd_entry), 23);
    bus_wr(8'h00, 32'h10);
    bus_wr(8'h10, 32'h0000_0020);
    chk("R6 first entry low", ent(0), 64'h0000_0000_0000_0020);
    chk("R10 used sticky", 64'(used_o), 64'(24'h800009));
  endtask

  task automatic t_undef();
    logic [31:0] d; logic e;
    logic [N*64-1:0] snap;
    logic saw;
    win_rd(8'h40, d);
    chk("R9 undefined read zero", d, 0);
    win_rd(8'h05, d);
    chk("R9 undefined read 0x05", d, 0);
    bus_wr(8'h00, 32'h40);
    bus_rd(8'h10, d, e);
    chk("R9 no error flag", 64'(e), 0);
    snap = entries_o;
    bus_wr(8'h10, 32'hFFFF_FFFF);
    saw = upd_strobe;
    chk("R9 write no strobe", 64'(saw), 0);
    chk("R9 entries unchanged", 64'(entries_o != snap), 0);
  endtask

  task automatic t_backpressure();
    logic [31:0] d; logic e;
    bus_wr(8'h00, 32'h01);
    rsp_ready = 1'b0;
    bus_rd(8'h10, d, e);
    chk("R12 response present", {rsp_valid, req_ready}, 2'b10);
    repeat (3) @(negedge clk);
    chk("R12 held data", {rsp_valid, rsp_err, rsp_data}, {2'b10, 32'h0017_0011});
    chk("R12 ready low while held", 64'(req_ready), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R12 drained", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_size();
    t_version();
    t_id();
    t_entry();
    t_undef();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule